// File: doc/BRIEF.md
# ECC Address Region Qualifier

This block tells a memory controller, for every access address, whether error-correction encoding and checking should apply to that access. Software programs a small set of configuration registers through a simple write/read port: one control word holding a global enable, a region-mode bit and one enable per address window, plus one register per window giving its lower and upper bounds. Each bound is the upper half of a 32-bit address, so windows are 64 KiB granular.

The upper bound is extended with all-ones in its low half, and the lower bound is extended with all-zeros, so a window written as lower `0x8000` and upper `0x8FFF` covers `0x8000_0000` through `0x8FFF_FFFF` inclusive. With the global enable set and the region mode cleared, every access is protected. With both set, only addresses falling inside at least one enabled window are protected. A configuration lock input freezes every register against writes. The `protect` output is combinational from the access address and the stored configuration.

Top module: `ecc_region_qual`

## Requirements
- R1: After reset every register reads back as zero and `protect` is 0 for any address.
- R2: While control bit 31 (global enable) is 0, `protect` is 0 for every address, whatever the other fields hold.
- R3: With control bit 31 set and control bit 30 (region mode) clear, `protect` is 1 for every address, whatever the windows hold.
- R4: With control bits 31 and 30 both set, `protect` is 1 exactly when the address lies inside at least one enabled window. Control bit 0 enables window 1 (select 1) and bit 1 enables window 2 (select 2).
- R5: A window covers addresses from {lower, 16'h0000} to {upper, 16'hFFFF} inclusive; the address one below the first and one above the last are outside.
- R6: A window whose enable bit is 0 never causes `protect` to be 1 in region mode.
- R7: A write presented while `cfg_lock` is 1 leaves the addressed register unchanged.
- R8: Select 0 reads the control word with bits 29:2 always zero; selects 1 and 2 read the window word with the upper bound in bits 31:16 and the lower bound in bits 15:0, exactly as written.
- R9: Select 3 reads as zero and a write to it changes no register.
- R10: A window whose lower bound exceeds its upper bound contains no address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_lock | input | 1 | When 1, register writes are dropped |
| reg_we | input | 1 | Register write strobe, taken on the rising edge |
| reg_sel | input | 2 | Register select: 0 control, 1 window 1, 2 window 2, 3 unused |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Combinational read data for `reg_sel` |
| acc_addr | input | 32 | Access address to qualify |
| protect | output | 1 | 1 when the access must use error correction |

## Verification
The assertions assume reset is held low across at least one rising edge and that `reg_we`, `reg_sel` and `cfg_lock` are settled before each edge, since the lock checks compare stored fields between consecutive edges. The bench changes every input only on falling edges and samples one nanosecond later, so each rising edge sees stable values. Random addresses are biased toward the window bounds and their neighbours so the inclusive limits are hit often, and random windows include inverted bounds.

// File: rtl/ecc_rq_pkg.sv
`timescale 1ns/1ps
// Shared constants and types for the ECC address region qualifier.
// Assumes a two-bit register select and a 32-bit register word.
package ecc_rq_pkg;
    localparam int CTRL_EN_BIT   = 31;
    localparam int CTRL_MODE_BIT = 30;
    localparam int MAX_RANGES    = 2;

    // Decoded control fields held by the register block.
    typedef struct packed {
        logic                  en;
        logic                  mode;
        logic [MAX_RANGES-1:0] rng_en;
    } ctrl_t;
endpackage

// File: rtl/ecc_rq_regs.sv
`timescale 1ns/1ps
// Configuration registers: one control word and NUM_RANGES window words.
// Writes are taken on the rising edge when reg_we is 1 and cfg_lock is 0.
// Reads are combinational. Assumes NUM_RANGES <= MAX_RANGES.
module ecc_rq_regs
    import ecc_rq_pkg::*;
#(
    parameter int DATA_W     = 32,
    parameter int NUM_RANGES = 2,
    parameter int SEL_W      = 2
) (
    input  logic                                   clk,
    input  logic                                   rst_n,
    input  logic                                   cfg_lock,
    input  logic                                   reg_we,
    input  logic [SEL_W-1:0]                       reg_sel,
    input  logic [DATA_W-1:0]                      reg_wdata,
    output logic [DATA_W-1:0]                      reg_rdata,
    output ctrl_t                                  ctrl_o,
    output logic [NUM_RANGES-1:0][DATA_W/2-1:0]    lo_o,
    output logic [NUM_RANGES-1:0][DATA_W/2-1:0]    hi_o
);
    localparam int HALF_W = DATA_W / 2;

    ctrl_t                                ctrl_q;
    logic [NUM_RANGES-1:0][HALF_W-1:0]    lo_q;
    logic [NUM_RANGES-1:0][HALF_W-1:0]    hi_q;
    logic                                 wr_ok;

    // Purpose: a write is accepted only while the lock is released.
    assign wr_ok = reg_we & ~cfg_lock;

    // Purpose: capture the control fields from a select-0 write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else if (wr_ok && reg_sel == SEL_W'(0)) begin
            ctrl_q.en     <= reg_wdata[CTRL_EN_BIT];
            ctrl_q.mode   <= reg_wdata[CTRL_MODE_BIT];
            ctrl_q.rng_en <= '0;
            ctrl_q.rng_en[NUM_RANGES-1:0] <= reg_wdata[NUM_RANGES-1:0];
        end
    end

    for (genvar g = 0; g < NUM_RANGES; g++) begin : g_win
        // Purpose: capture window g bounds from a select g+1 write.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                lo_q[g] <= '0;
                hi_q[g] <= '0;
            end else if (wr_ok && reg_sel == SEL_W'(g + 1)) begin
                hi_q[g] <= reg_wdata[DATA_W-1:HALF_W];
                lo_q[g] <= reg_wdata[HALF_W-1:0];
            end
        end

        // R7: a locked edge leaves the window bounds as they were
        a_r7_lock_window: assert property (@(posedge clk) disable iff (!rst_n)
            cfg_lock |=> ($stable(lo_q[g]) && $stable(hi_q[g])));
    end

    // Purpose: return the addressed register, zero for unused selects.
    always_comb begin
        reg_rdata = '0;
        if (reg_sel == SEL_W'(0)) begin
            reg_rdata[CTRL_EN_BIT]      = ctrl_q.en;
            reg_rdata[CTRL_MODE_BIT]    = ctrl_q.mode;
            reg_rdata[NUM_RANGES-1:0]   = ctrl_q.rng_en[NUM_RANGES-1:0];
        end
        for (int k = 0; k < NUM_RANGES; k++) begin
            if (reg_sel == SEL_W'(k + 1)) begin
                reg_rdata = {hi_q[k], lo_q[k]};
            end
        end
    end

    assign ctrl_o = ctrl_q;
    assign lo_o   = lo_q;
    assign hi_o   = hi_q;

    // R7: a locked edge leaves the control fields as they were
    a_r7_lock_ctrl: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_lock |=> $stable(ctrl_q));

    // R8: reserved control bits always read back as zero
    a_r8_rsvd_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_sel == SEL_W'(0)) |-> (reg_rdata[CTRL_MODE_BIT-1:NUM_RANGES] == '0));
endmodule

// File: rtl/ecc_rq_window.sv
`timescale 1ns/1ps
// One address window comparator. The lower bound is padded with zeros and
// the upper bound with ones, giving an inclusive 64 KiB-granular window.
// An inverted window (lower above upper) matches nothing by construction.
module ecc_rq_window #(
    parameter int ADDR_W = 32
) (
    input  logic [ADDR_W-1:0]   addr,
    input  logic [ADDR_W/2-1:0] lo,
    input  logic [ADDR_W/2-1:0] hi,
    output logic                hit
);
    localparam int HALF_W = ADDR_W / 2;

    logic [ADDR_W-1:0] lo_full;
    logic [ADDR_W-1:0] hi_full;

    // Purpose: widen the bounds to full addresses.
    assign lo_full = {lo, {HALF_W{1'b0}}};
    assign hi_full = {hi, {HALF_W{1'b1}}};

    // Purpose: inclusive compare against both ends.
    assign hit = (addr >= lo_full) && (addr <= hi_full);
endmodule

// File: rtl/ecc_rq_decide.sv
`timescale 1ns/1ps
// Combines the control fields with the window hits into the protect flag.
// Assumes hits arrive combinationally from the window comparators.
module ecc_rq_decide
    import ecc_rq_pkg::*;
#(
    parameter int NUM_RANGES = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  ctrl_t                 ctrl,
    input  logic [NUM_RANGES-1:0] hits,
    output logic                  protect
);
    logic any_hit;

    // Purpose: a window counts only when its enable bit is set.
    assign any_hit = |(hits & ctrl.rng_en[NUM_RANGES-1:0]);

    // Purpose: global enable gates all; mode picks windowed or everywhere.
    assign protect = ctrl.en & (ctrl.mode ? any_hit : 1'b1);

    // R2: nothing is protected while the global enable is clear
    a_r2_global_off: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl.en |-> !protect);

    // R3: enable without region mode protects every address
    a_r3_all_protected: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl.en && !ctrl.mode) |-> protect);

    // R6: disabled windows never contribute in region mode
    a_r6_disabled_window: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl.en && ctrl.mode && ctrl.rng_en[NUM_RANGES-1:0] == '0) |-> !protect);

    // R4: in region mode a protected access lies in some comparator window
    a_r4_needs_hit: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl.mode && protect) |-> (hits != '0));
endmodule

// File: rtl/ecc_region_qual.sv
`timescale 1ns/1ps
// Top of the ECC address region qualifier: register block, one comparator
// per window and the decision stage. protect is combinational from
// acc_addr and the stored configuration.
module ecc_region_qual
    import ecc_rq_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int NUM_RANGES = 2,
    parameter int SEL_W      = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_lock,
    input  logic              reg_we,
    input  logic [SEL_W-1:0]  reg_sel,
    input  logic [ADDR_W-1:0] reg_wdata,
    output logic [ADDR_W-1:0] reg_rdata,
    input  logic [ADDR_W-1:0] acc_addr,
    output logic              protect
);
    localparam int HALF_W = ADDR_W / 2;

    ctrl_t                              ctrl;
    logic [NUM_RANGES-1:0][HALF_W-1:0]  lo;
    logic [NUM_RANGES-1:0][HALF_W-1:0]  hi;
    logic [NUM_RANGES-1:0]              hits;

    ecc_rq_regs #(
        .DATA_W     (ADDR_W),
        .NUM_RANGES (NUM_RANGES),
        .SEL_W      (SEL_W)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_lock  (cfg_lock),
        .reg_we    (reg_we),
        .reg_sel   (reg_sel),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .ctrl_o    (ctrl),
        .lo_o      (lo),
        .hi_o      (hi)
    );

    for (genvar g = 0; g < NUM_RANGES; g++) begin : g_cmp
        ecc_rq_window #(
            .ADDR_W (ADDR_W)
        ) u_win (
            .addr (acc_addr),
            .lo   (lo[g]),
            .hi   (hi[g]),
            .hit  (hits[g])
        );
    end

    ecc_rq_decide #(
        .NUM_RANGES (NUM_RANGES)
    ) u_decide (
        .clk     (clk),
        .rst_n   (rst_n),
        .ctrl    (ctrl),
        .hits    (hits),
        .protect (protect)
    );
endmodule

// File: tb/ecc_region_qual_test.sv
`timescale 1ns/1ps
// Bench: directed corner cases then seeded random traffic, each compared
// with a reference model kept in bench variables.
module ecc_region_qual_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_lock = 1'b0;
    logic        reg_we = 1'b0;
    logic [1:0]  reg_sel = 2'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [31:0] acc_addr = '0;
    logic        protect;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    logic [31:0] m_ctrl;
    logic [31:0] m_win [2];

    always #4 clk = ~clk;

    ecc_region_qual uut (
        .clk(clk), .rst_n(rst_n), .cfg_lock(cfg_lock), .reg_we(reg_we),
        .reg_sel(reg_sel), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .acc_addr(acc_addr), .protect(protect)
    );

    function automatic logic [31:0] exp_rd(input logic [1:0] s);
        if (s == 2'd0) return m_ctrl;
        if (s == 2'd3) return 32'h0;
        return m_win[s-1];
    endfunction

    function automatic logic exp_prot(input logic [31:0] a);
        logic h;
        h = 1'b0;
        for (int k = 0; k < 2; k++) begin
            if (m_ctrl[k] && a >= {m_win[k][15:0], 16'h0000}
                          && a <= {m_win[k][31:16], 16'hFFFF}) h = 1'b1;
        end
        if (!m_ctrl[31]) return 1'b0;
        if (!m_ctrl[30]) return 1'b1;
        return h;
    endfunction

    task automatic do_wr(input logic [1:0] s, input logic [31:0] d, input logic lk);
        @(negedge clk);
        reg_we = 1'b1; reg_sel = s; reg_wdata = d; cfg_lock = lk;
        @(negedge clk);
        reg_we = 1'b0; cfg_lock = 1'b0;
        if (!lk) begin
            if (s == 2'd0) m_ctrl = d & 32'hC000_0003;
            else if (s != 2'd3) m_win[s-1] = d;
        end
    endtask

    task automatic chk_rd(input logic [1:0] s, input string tag);
        reg_sel = s;
        #1;
        n_chk++;
        if (reg_rdata !== exp_rd(s)) begin
            n_bad++;
            $display("FAIL %s: sel %0d read %h expected %h", tag, s, reg_rdata, exp_rd(s));
        end
    endtask

    task automatic chk_prot(input logic [31:0] a, input string tag);
        acc_addr = a;
        #1;
        n_chk++;
        if (protect !== exp_prot(a)) begin
            n_bad++;
            $display("FAIL %s: addr %h protect %b expected %b", tag, a, protect, exp_prot(a));
        end
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        #1_200_000;
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: run hung, expected completion");
            finish_run();
        end
    end

    initial begin
        logic [31:0] a, d;
        logic [1:0]  s;
        m_ctrl = '0; m_win[0] = '0; m_win[1] = '0;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset contents and output
        for (int s2 = 0; s2 < 4; s2++) chk_rd(2'(s2), "R1");
        chk_prot(32'h8000_0000, "R1");

        do_wr(2'd1, 32'h8FFF_8000, 1'b0);
        do_wr(2'd2, 32'h9FFF_9000, 1'b0);
        chk_rd(2'd1, "R8"); chk_rd(2'd2, "R8");

        // R2: global enable clear, other fields set
        do_wr(2'd0, 32'h4000_0003, 1'b0);
        chk_prot(32'h8000_0000, "R2");
        chk_prot(32'h9ABC_0000, "R2");

        // R3: protect everywhere
        do_wr(2'd0, 32'h8000_0000, 1'b0);
        chk_prot(32'h0000_0000, "R3");
        chk_prot(32'hFFFF_FFFF, "R3");

        // R4/R5/R6: window 1 only
        do_wr(2'd0, 32'hC000_0001, 1'b0);
        chk_prot(32'h8000_0000, "R5");
        chk_prot(32'h7FFF_FFFF, "R5");
        chk_prot(32'h8FFF_FFFF, "R5");
        chk_prot(32'h9000_0000, "R6");
        chk_prot(32'h8123_4567, "R4");

        // R4: both windows
        do_wr(2'd0, 32'hC000_0003, 1'b0);
        chk_prot(32'h9000_0000, "R4");
        chk_prot(32'h9FFF_FFFF, "R5");
        chk_prot(32'hA000_0000, "R5");

        // R7: locked writes dropped
        do_wr(2'd0, 32'h0000_0000, 1'b1);
        chk_rd(2'd0, "R7");
        do_wr(2'd1, 32'h1111_2222, 1'b1);
        chk_rd(2'd1, "R7");
        chk_prot(32'h8000_0000, "R7");

        // R8: reserved bits dropped
        do_wr(2'd0, 32'hFFFF_FFFF, 1'b0);
        chk_rd(2'd0, "R8");

        // R9: unused select
        do_wr(2'd3, 32'hDEAD_BEEF, 1'b0);
        chk_rd(2'd3, "R9");
        chk_rd(2'd0, "R9"); chk_rd(2'd1, "R9"); chk_rd(2'd2, "R9");

        // R10: inverted window
        do_wr(2'd0, 32'hC000_0001, 1'b0);
        do_wr(2'd1, 32'h1000_2000, 1'b0);
        chk_prot(32'h1500_0000, "R10");
        chk_prot(32'h2000_0000, "R10");

        // Random mix, all requirements (R4, R5, R7 weighted)
        for (int i = 0; i < 600; i++) begin
            s = 2'($urandom_range(0, 3));
            d = $urandom();
            if ($urandom_range(0, 3) == 0) d[31:30] = 2'b11;
            do_wr(s, d, 1'($urandom_range(0, 3) == 0));
            chk_rd(s, "R7");
            for (int j = 0; j < 4; j++) begin
                a = $urandom();
                case ($urandom_range(0, 4))
                    0: a = {m_win[0][15:0], 16'h0000} - 32'($urandom_range(0, 1));
                    1: a = {m_win[0][31:16], 16'hFFFF} + 32'($urandom_range(0, 1));
                    2: a = {m_win[1][15:0], 16'h0000} - 32'($urandom_range(0, 1));
                    3: a = {m_win[1][31:16], 16'hFFFF} + 32'($urandom_range(0, 1));
                    default: ;
                endcase
                chk_prot(a, "R4");
            end
        end

        done = 1;
        finish_run();
    end
endmodule